// File: doc/BRIEF.md
# Sparse Column Hit Readout with Priority Encoding

This block turns a grid of binary pixel hit flags into a sparse stream of pixel addresses. Every pixel owns a one-bit latch that a hit pulse sets. Each column ranks its own latches by row index through a purely combinational chain and places the address of its top-ranked pixel on its own address bus. At the bottom of the array a collector visits the columns in turn and forwards one address word per accepted handshake. The latch behind a word is cleared only in the cycle that word is accepted. Pixels without a hit never produce a word.

Readout runs in frames. A trigger records which latches are set at that moment. The block then drains exactly those pixels and closes the frame with a single end-of-frame word. Hits that arrive while a frame is draining stay latched and wait for the next trigger. The receiver can hold ready low for as long as it needs. No word is lost and no latch is cleared while the output is stalled.

Top module: `colpe_readout`

## Requirements
- R1: Out of reset `vld_o` is low. `vld_o` stays low at all times except while a frame is being drained, even when hits are latched.
- R2: A one-cycle pulse on `hit_i[c*NROWS + r]` sets the latch of pixel (column c, row r). The latch stays set, with no trigger, for any number of cycles until that pixel is served.
- R3: Within one column, the set pixel with the lowest row index is served first.
- R4: Across columns, every frame starts its search at column 0. After a word from column c is accepted, the next word comes from the first column after c, counting cyclically, that still has pending pixels. Empty columns are skipped.
- R5: Word layout: bit W-1 is the end-of-frame flag, bits [W-2:RW] are the column, and bits [RW-1:0] are the row, with W = 1 + CW + RW. Each pixel latched at the trigger gives exactly one word per frame, and no other pixel gives a word.
- R6: A trigger while idle snapshots the latches, and the first word is presented in the next cycle. A trigger while a frame is draining has no effect.
- R7: While `vld_o` is high and `rdy_i` is low, the presented word does not change and no latch is cleared.
- R8: After the last pending word of a frame is accepted, one end-of-frame word (flag 1, all other bits 0) is presented. Once it is accepted, `vld_o` goes low. A frame with no latched pixels gives only this word.
- R9: A hit that arrives after the trigger is not included in the current frame. It is read out in the next frame.
- R10: A hit on a pixel in the same cycle that its word is accepted leaves the latch set, and the pixel is read out again in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Periphery clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hit_i | input | NCOLS*NROWS | Hit pulses from the discriminators, bit c*NROWS+r |
| trig_i | input | 1 | Frame trigger |
| rdy_i | input | 1 | Downstream ready |
| vld_o | output | 1 | Word valid |
| word_o | output | 1+CW+RW | {end-of-frame flag, column, row} |

## Verification
The bench goes after the ordering corners first: several hits in one column interleaved with hits in other columns, a full array, and an empty frame. A collector that stayed on one column, or that restarted its search at column 0 after every word, would put the words out of order. A design without the final marker would hang or end the frame early. Stalls of several cycles check that the presented word holds steady. A design that cleared its latch before the handshake would either skip that pixel or send it twice. Two timing corners are also covered: a hit landing in the cycle its own word is accepted, and a hit arriving together with a second trigger in the middle of a drain. A design that let clear win over set, or that admitted late hits into the running frame, would lose the pixel or move it into the wrong frame.

// File: rtl/colpe_pkg.sv
package colpe_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_DRAIN = 1'b1
   } frame_st_e;

endpackage

// File: rtl/colpe_column.sv
module colpe_column #(
   parameter int NROWS = 8,
   localparam int RW = $clog2(NROWS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NROWS-1:0] hit_i,
   input  logic             snap_i,
   input  logic             serve_i,
   output logic             pend_o,
   output logic [RW-1:0]    row_o
);

   logic [NROWS-1:0] lat_q;
   logic [NROWS-1:0] memb_q;
   logic [NROWS-1:0] elig;
   logic [NROWS-1:0] first_oh;
   logic [NROWS-1:0] clr_vec;

   // combinational priority chain, lowest row wins
   always_comb begin
      elig     = lat_q & memb_q;
      first_oh = elig & (~elig + {{(NROWS-1){1'b0}}, 1'b1});
      clr_vec  = serve_i ? first_oh : '0;
      row_o    = '0;
      for (int r = NROWS - 1; r >= 0; r--) begin
         if (elig[r]) row_o = RW'(r);
      end
   end

   assign pend_o = |elig;

   // set wins over clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lat_q  <= '0;
         memb_q <= '0;
      end else begin
         lat_q  <= (lat_q & ~clr_vec) | hit_i;
         memb_q <= snap_i ? lat_q : (memb_q & ~clr_vec);
      end
   end

endmodule

// File: rtl/colpe_rr_arb.sv
module colpe_rr_arb #(
   parameter int NCOLS = 4,
   localparam int CW = $clog2(NCOLS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NCOLS-1:0] req_i,
   input  logic             restart_i,
   input  logic             adv_i,
   output logic             any_o,
   output logic [CW-1:0]    gnt_o
);

   logic [CW-1:0] ptr_q;
   logic          found;

   always_comb begin
      found = 1'b0;
      gnt_o = '0;
      for (int i = 0; i < NCOLS; i++) begin
         int idx;
         idx = int'(ptr_q) + i;
         if (idx >= NCOLS) idx = idx - NCOLS;
         if (!found && req_i[idx]) begin
            found = 1'b1;
            gnt_o = CW'(idx);
         end
      end
   end

   assign any_o = |req_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
      end else if (restart_i) begin
         ptr_q <= '0;
      end else if (adv_i) begin
         ptr_q <= (gnt_o == CW'(NCOLS - 1)) ? '0 : gnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/colpe_readout.sv
module colpe_readout #(
   parameter int NCOLS = 4,
   parameter int NROWS = 8,
   localparam int CW = $clog2(NCOLS),
   localparam int RW = $clog2(NROWS),
   localparam int NPIX = NCOLS * NROWS,
   localparam int WORD_W = 1 + CW + RW
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NPIX-1:0]   hit_i,
   input  logic              trig_i,
   input  logic              rdy_i,
   output logic              vld_o,
   output logic [WORD_W-1:0] word_o
);
   import colpe_pkg::*;

   if (NCOLS < 2) begin : g_bad_cols
      $error("colpe_readout: NCOLS must be at least 2");
   end
   if (NROWS < 2) begin : g_bad_rows
      $error("colpe_readout: NROWS must be at least 2");
   end

   frame_st_e     st_q;
   logic          busy;
   logic          snap;
   logic          fire;
   logic          word_fire;
   logic          eof_fire;
   logic          any_pend;
   logic [CW-1:0] gnt;
   logic [NCOLS-1:0] col_pend;
   logic [RW-1:0]    col_row [NCOLS];

   assign busy      = (st_q == ST_DRAIN);
   assign snap      = !busy && trig_i;
   assign fire      = busy && rdy_i;
   assign word_fire = fire && any_pend;
   assign eof_fire  = fire && !any_pend;

   for (genvar c = 0; c < NCOLS; c++) begin : g_col
      colpe_column #(.NROWS(NROWS)) col_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .hit_i  (hit_i[c*NROWS +: NROWS]),
         .snap_i (snap),
         .serve_i(word_fire && (gnt == CW'(c))),
         .pend_o (col_pend[c]),
         .row_o  (col_row[c])
      );
   end

   colpe_rr_arb #(.NCOLS(NCOLS)) arb_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (col_pend),
      .restart_i(snap),
      .adv_i    (word_fire),
      .any_o    (any_pend),
      .gnt_o    (gnt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       st_q <= ST_IDLE;
      else if (snap)     st_q <= ST_DRAIN;
      else if (eof_fire) st_q <= ST_IDLE;
   end

   assign vld_o  = busy;
   assign word_o = any_pend ? {1'b0, gnt, col_row[gnt]}
                            : {1'b1, {(CW + RW){1'b0}}};

endmodule

// File: rtl/colpe_readout_chk.sv
module colpe_readout_chk #(
   parameter int W = 6
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         trig_i,
   input logic         rdy_i,
   input logic         vld_o,
   input logic [W-1:0] word_o,
   input logic         busy_i
);

   // R1
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_i |-> !vld_o);

   // R6
   trig_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_i && trig_i) |=> vld_o);

   // R7
   stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o && !rdy_i) |=> (vld_o && $stable(word_o)));

   // R8
   eof_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o && word_o[W-1]) |-> (word_o[W-2:0] == '0));

   // R8
   eof_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_o && rdy_i && word_o[W-1]) |=> !vld_o);

endmodule

bind colpe_readout colpe_readout_chk #(.W(WORD_W)) chk_i (
   .clk_i (clk_i),
   .rst_ni(rst_ni),
   .trig_i(trig_i),
   .rdy_i (rdy_i),
   .vld_o (vld_o),
   .word_o(word_o),
   .busy_i(busy)
);

// File: tb/colpe_readout_tb_top.sv
module colpe_readout_tb_top;

   localparam int NC = 4;
   localparam int NR = 8;
   localparam int NP = NC * NR;
   localparam int WW = 6;
   localparam logic [WW-1:0] EOF_W = 6'b100000;
   localparam int NVEC = 8;
   localparam logic [NP-1:0] VEC [NVEC] = '{
      32'h0000_0001, 32'h8000_0000, 32'h0000_0081, 32'h0101_0101,
      32'h0300_0C05, 32'hFFFF_FFFF, 32'h0000_0000, 32'h00F0_0000
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0] hit = '0;
   logic trig = 1'b0;
   logic rdy = 1'b1;
   logic vld;
   logic [WW-1:0] word;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   logic [WW-1:0] got [64];
   int got_n;
   logic [WW-1:0] exp_w [64];
   int exp_n;

   always #10 clk = ~clk;

   colpe_readout #(.NCOLS(NC), .NROWS(NR)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .trig_i(trig),
      .rdy_i(rdy), .vld_o(vld), .word_o(word)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         failures = failures + 1;
         $display("FAIL watchdog act=%0d exp=<20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   task automatic inject(input logic [NP-1:0] pat);
      hit = pat;
      tick();
      hit = '0;
   endtask

   // collect from current cycle until the end-of-frame word is accepted
   task automatic collect();
      for (int g = 0; g < 200; g++) begin
         if (vld && rdy) begin
            got[got_n] = word;
            got_n++;
            if (word[WW-1]) begin
               tick();
               return;
            end
         end
         tick();
      end
   endtask

   task automatic run_frame();
      trig = 1'b1;
      tick();
      trig = 1'b0;
      got_n = 0;
      collect();
   endtask

   // expected order from the requirements (R3, R4, R5, R8)
   task automatic build_exp(input logic [NP-1:0] pat);
      logic [NP-1:0] rem;
      int ptr;
      rem = pat;
      ptr = 0;
      exp_n = 0;
      while (rem != '0) begin
         bit done;
         done = 1'b0;
         for (int k = 0; k < NC; k++) begin
            int c;
            c = (ptr + k) % NC;
            if (!done && rem[c*NR +: NR] != '0) begin
               for (int r = 0; r < NR; r++) begin
                  if (!done && rem[c*NR + r]) begin
                     exp_w[exp_n] = {1'b0, 2'(c), 3'(r)};
                     exp_n++;
                     rem[c*NR + r] = 1'b0;
                     ptr = (c + 1) % NC;
                     done = 1'b1;
                  end
               end
            end
         end
      end
      exp_w[exp_n] = EOF_W;
      exp_n++;
   endtask

   task automatic compare(input string req);
      check(got_n == exp_n, {req, " word count"}, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++)
         check(got[i] == exp_w[i], req, int'(got[i]), int'(exp_w[i]));
   endtask

   initial begin
      repeat (3) tick();
      // R1: reset state
      check(vld == 1'b0, "R1 reset vld", int'(vld), 0);
      rst_n = 1'b1;
      tick();

      // R1, R2: hits with no trigger give nothing but persist
      inject(32'h0010_0200);
      repeat (10) begin
         check(vld == 1'b0, "R1 idle with hits", int'(vld), 0);
         tick();
      end
      run_frame();
      build_exp(32'h0010_0200);
      compare("R2 persisted hits");

      // R3 R4 R5 R8: vector table
      for (int v = 0; v < NVEC; v++) begin
         inject(VEC[v]);
         run_frame();
         build_exp(VEC[v]);
         compare(VEC[v] == '0 ? "R8 empty frame" : "R3 R4 R5 vector");
         check(vld == 1'b0, "R8 idle after frame", int'(vld), 0);
      end

      // R7: stall holds word, no latch lost
      inject(32'h0020_0000);
      trig = 1'b1;
      tick();
      trig = 1'b0;
      rdy = 1'b0;
      check(vld && word == 6'b010101, "R7 first word", int'(word), 6'b010101);
      repeat (4) begin
         tick();
         check(vld && word == 6'b010101, "R7 stalled word", int'(word), 6'b010101);
      end
      rdy = 1'b1;
      got_n = 0;
      collect();
      build_exp(32'h0020_0000);
      compare("R7 after stall");

      // R10: set on same cycle as clear keeps the latch
      inject(32'h0000_0800);
      trig = 1'b1;
      tick();
      trig = 1'b0;
      check(vld && word == 6'b001011, "R10 served word", int'(word), 6'b001011);
      hit = 32'h0000_0800;
      tick();
      hit = '0;
      check(vld && word == EOF_W, "R10 frame closes", int'(word), int'(EOF_W));
      tick();
      run_frame();
      build_exp(32'h0000_0800);
      compare("R10 re-hit next frame");

      // R9 and R6: late hit and mid-drain trigger
      inject(32'h0000_0003);
      trig = 1'b1;
      tick();
      got_n = 0;
      got[got_n] = word;
      got_n++;
      hit = 32'h0010_0000;
      trig = 1'b1;
      tick();
      hit = '0;
      trig = 1'b0;
      collect();
      build_exp(32'h0000_0003);
      compare("R9 R6 late hit excluded");
      check(vld == 1'b0, "R6 no extra frame", int'(vld), 0);
      run_frame();
      build_exp(32'h0010_0000);
      compare("R9 late hit next frame");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule